// File: doc/BRIEF.md
# Delayed-Trigger Ring Sampling Controller

This block sequences a circular array of sampling cells. While armed, it emits a write address that advances by one cell on every clock and wraps around a ring of 2^ADDR_W cells (1024 by default). A trigger does not halt the ring at once. Instead, a countdown of programmable length starts, and writing continues until that countdown runs out. The cell written last is then frozen as the stop cell.

After the halt, a read sequencer walks a window of programmable length that ends at the stop cell, so the oldest sample in the window comes first. For each cell, the NCH channel values are handed out over NLANES output lanes in NCH/NLANES consecutive slots. Readout runs at a slow rate: one strobe every RD_DIV clocks. The total readout time is therefore (NCH/NLANES) x window length x RD_DIV clocks, and a short window keeps it brief. A busy flag covers the whole period from an accepted trigger to the last strobe. After that, an arm pulse resumes writing at the cell that follows the stop cell.

NCH must be a multiple of NLANES, and RD_DIV must be at least 2.

Top module: `ring_roi_ctrl`

## Requirements
- R1: After reset, wr_en, busy and rd_valid are low and wr_addr is 0. The first arm pulse starts writing at cell 0.
- R2: While wr_en is high, wr_addr increases by one on every clock and wraps from 2^ADDR_W-1 to 0.
- R3: A trigger is accepted in a writing cycle whose address is A, with cfg_delay = D. Writing then continues for exactly D more clocks, and the stop cell is (A + D) mod 2^ADDR_W. With D = 0 the stop cell is A itself. wr_en is low from the next cycle on.
- R4: Let L be the window length: cfg_roi, where 0 means the full ring. Readout visits L cells. The first cell is (stop + 1 - L) mod 2^ADDR_W, each next cell is one higher with wrap-around, and the last cell is the stop cell.
- R5: Each visited cell gets NCH/NLANES strobes, with rd_slot running 0, 1, and so on in order. During a strobe in slot s, lane l (bits [l*DW +: DW] of lane_data) carries channel s*NLANES + l (bits [c*DW +: DW] of ch_data).
- R6: Consecutive strobes are exactly RD_DIV clocks apart. The first strobe comes RD_DIV+1 clocks after the last writing cycle.
- R7: The block ignores a trigger that comes during the countdown, during readout, or while it is halted and idle. Such a trigger changes neither the stop cell nor the strobe sequence, and it does not raise busy.
- R8: busy rises in the cycle after an accepted trigger and stays high through the final strobe. It is low in the cycle after that strobe.
- R9: An arm pulse given while halted and not busy resumes writing at (stop + 1) mod 2^ADDR_W. An arm pulse given while busy has no effect.
- R10: cfg_delay and cfg_roi are taken only at the accepted trigger. Changing them while busy does not alter the capture in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling and readout |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Start or resume writing when halted and not busy |
| trig | input | 1 | Trigger; honoured only while writing and not busy |
| cfg_delay | input | DLY_W | Clocks of writing after the trigger |
| cfg_roi | input | ADDR_W | Window length in cells; 0 means the full ring |
| ch_data | input | NCH*DW | Digitised channel values for the cell on rd_addr |
| wr_en | output | 1 | A cell is being written in this cycle |
| wr_addr | output | ADDR_W | Cell written in this cycle |
| busy | output | 1 | Capture or readout in progress |
| rd_valid | output | 1 | Readout strobe |
| rd_addr | output | ADDR_W | Cell being read out |
| rd_slot | output | SLOT_W | Channel group on the lanes |
| lane_data | output | NLANES*DW | Channel values placed on the output lanes |

## Verification
The hardest case to reach is a window that crosses cell 0, combined with stray events while busy. That means a trigger placed so the countdown carries the stop cell past the end of the ring, with extra triggers, arm pulses and configuration changes arriving during both the countdown and the readout. The stimulus polls wr_addr and raises the trigger exactly when the ring reaches a chosen cell near the top, so the halt lands a few cells after the wrap. It then injects the disturbances at counted cycles. Further runs cover a zero delay with a one-cell window, a full-ring window, and a delay longer than the ring.

// File: rtl/ring_roi_pkg.sv
package ring_roi_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_RUN   = 2'd1,
        CAP_DELAY = 2'd2,
        CAP_HOLD  = 2'd3
    } cap_state_e;

endpackage

// File: rtl/ring_capture.sv
module ring_capture
    import ring_roi_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DLY_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [ADDR_W-1:0] cfg_roi,
    input  logic              rd_done,
    output logic              writing,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              busy,
    output logic              launch,
    output logic [ADDR_W-1:0] stop_cell,
    output logic [ADDR_W:0]   roi_len
);

    localparam logic [ADDR_W:0]  ROI_FULL = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [DLY_W-1:0] CNT_LAST = DLY_W'(1);

    typedef struct packed {
        cap_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [DLY_W-1:0]  cnt;
        logic [ADDR_W-1:0] stop;
        logic [ADDR_W:0]   roi;
        logic              launch;
    } cap_s;

    cap_s c_d, c_q;

    always_comb begin
        c_d        = c_q;
        c_d.launch = 1'b0;
        case (c_q.st)
            CAP_IDLE: begin
                if (arm) begin
                    c_d.st = CAP_RUN;
                end
            end
            CAP_RUN: begin
                c_d.ptr = c_q.ptr + 1'b1;
                if (trig) begin
                    c_d.roi = (cfg_roi == '0) ? ROI_FULL : {1'b0, cfg_roi};
                    if (cfg_delay == '0) begin
                        c_d.stop   = c_q.ptr;
                        c_d.st     = CAP_HOLD;
                        c_d.launch = 1'b1;
                    end else begin
                        c_d.cnt = cfg_delay;
                        c_d.st  = CAP_DELAY;
                    end
                end
            end
            CAP_DELAY: begin
                c_d.ptr = c_q.ptr + 1'b1;
                c_d.cnt = c_q.cnt - 1'b1;
                if (c_q.cnt == CNT_LAST) begin
                    c_d.stop   = c_q.ptr;
                    c_d.st     = CAP_HOLD;
                    c_d.launch = 1'b1;
                end
            end
            CAP_HOLD: begin
                if (rd_done) begin
                    c_d.st = CAP_IDLE;
                end
            end
            default: c_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign writing   = (c_q.st == CAP_RUN) || (c_q.st == CAP_DELAY);
    assign busy      = (c_q.st == CAP_DELAY) || (c_q.st == CAP_HOLD);
    assign wr_ptr    = c_q.ptr;
    assign launch    = c_q.launch;
    assign stop_cell = c_q.stop;
    assign roi_len   = c_q.roi;

    // R2: consecutive writing cycles step the pointer by one with wrap
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        writing |=> (!writing || wr_ptr == $past(wr_ptr) + 1'b1));

    // R3: at launch writing has ended and the stop cell trails the pointer
    a_r3_halt_point: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!writing && stop_cell == ADDR_W'(wr_ptr - 1'b1)));

    // R7: the stop cell stays frozen while held
    a_r7_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == CAP_HOLD) |=> $stable(c_q.stop));

    // R7: a single launch per capture
    a_r7_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    // R10: window length is frozen during the countdown
    a_r10_roi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == CAP_DELAY) |=> $stable(c_q.roi));

endmodule

// File: rtl/ring_roi_reader.sv
module ring_roi_reader #(
    parameter int ADDR_W = 10,
    parameter int SLOTS  = 4,
    parameter int RD_DIV = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] stop_cell,
    input  logic [ADDR_W:0]   roi_len,
    output logic              strobe,
    output logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output logic              done
);

    localparam int DIV_W = (RD_DIV > 1) ? $clog2(RD_DIV) : 1;
    localparam logic [DIV_W-1:0]  DIV_TOP   = DIV_W'(RD_DIV - 1);
    localparam logic [SLOT_W-1:0] SLOT_TOP  = SLOT_W'(SLOTS - 1);
    localparam logic [ADDR_W:0]   LEFT_LAST = (ADDR_W+1)'(1);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W:0]   left;
        logic [DIV_W-1:0]  div;
    } rd_s;

    rd_s  r_d, r_q;
    logic tick;
    logic last_slot;

    always_comb begin
        r_d       = r_q;
        tick      = r_q.active && (r_q.div == DIV_TOP);
        last_slot = (r_q.slot == SLOT_TOP);
        if (launch) begin
            r_d.active = 1'b1;
            r_d.addr   = stop_cell + 1'b1 - roi_len[ADDR_W-1:0];
            r_d.slot   = '0;
            r_d.left   = roi_len;
            r_d.div    = '0;
        end else if (r_q.active) begin
            if (tick) begin
                r_d.div = '0;
                if (last_slot) begin
                    r_d.slot = '0;
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == LEFT_LAST) begin
                        r_d.active = 1'b0;
                    end
                end else begin
                    r_d.slot = r_q.slot + 1'b1;
                end
            end else begin
                r_d.div = r_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign strobe = tick;
    assign addr   = r_q.addr;
    assign slot   = r_q.slot;
    assign done   = tick && last_slot && (r_q.left == LEFT_LAST);

    // R6: strobes never come back to back
    a_r6_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R5: the slot index stays within the channel groups
    a_r5_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.active |-> (r_q.slot <= SLOT_TOP));

    // R4: the walk never runs past the last window cell
    a_r4_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !r_q.active);

endmodule

// File: rtl/ring_lane_mux.sv
module ring_lane_mux #(
    parameter int NCH    = 8,
    parameter int NLANES = 2,
    parameter int DW     = 8,
    localparam int SLOTS  = NCH / NLANES,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [NCH*DW-1:0]    ch_data,
    input  logic [SLOT_W-1:0]    slot,
    output logic [NLANES*DW-1:0] lane_data
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) + 1 : 2;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [CH_W-1:0] ch_idx;
        assign ch_idx = CH_W'(slot) * CH_W'(NLANES) + CH_W'(l);
        assign lane_data[l*DW +: DW] = ch_data[int'(ch_idx)*DW +: DW];
    end

endmodule

// File: rtl/ring_roi_ctrl.sv
module ring_roi_ctrl #(
    parameter int ADDR_W = 10,
    parameter int DLY_W  = 12,
    parameter int NCH    = 8,
    parameter int NLANES = 2,
    parameter int DW     = 8,
    parameter int RD_DIV = 4,
    localparam int SLOTS  = NCH / NLANES,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic                 trig,
    input  logic [DLY_W-1:0]     cfg_delay,
    input  logic [ADDR_W-1:0]    cfg_roi,
    input  logic [NCH*DW-1:0]    ch_data,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic                 busy,
    output logic                 rd_valid,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic [SLOT_W-1:0]    rd_slot,
    output logic [NLANES*DW-1:0] lane_data
);

    logic              launch;
    logic              rd_done;
    logic [ADDR_W-1:0] stop_cell;
    logic [ADDR_W:0]   roi_len;

    ring_capture #(
        .ADDR_W (ADDR_W),
        .DLY_W  (DLY_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .trig      (trig),
        .cfg_delay (cfg_delay),
        .cfg_roi   (cfg_roi),
        .rd_done   (rd_done),
        .writing   (wr_en),
        .wr_ptr    (wr_addr),
        .busy      (busy),
        .launch    (launch),
        .stop_cell (stop_cell),
        .roi_len   (roi_len)
    );

    ring_roi_reader #(
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS),
        .RD_DIV (RD_DIV)
    ) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .stop_cell (stop_cell),
        .roi_len   (roi_len),
        .strobe    (rd_valid),
        .addr      (rd_addr),
        .slot      (rd_slot),
        .done      (rd_done)
    );

    ring_lane_mux #(
        .NCH    (NCH),
        .NLANES (NLANES),
        .DW     (DW)
    ) u_lanes (
        .ch_data   (ch_data),
        .slot      (rd_slot),
        .lane_data (lane_data)
    );

    // R8: every strobe falls inside the busy period
    a_r8_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    // R9: no writing while a readout is running
    a_r9_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !wr_en);

    // R8: busy falls only right after the final strobe
    a_r8_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rd_done));

endmodule

// File: tb/ring_roi_ctrl_test.sv
module ring_roi_ctrl_test;

    localparam int AW   = 10;
    localparam int DLW  = 12;
    localparam int NCH  = 8;
    localparam int NL   = 2;
    localparam int DW   = 8;
    localparam int RDIV = 4;
    localparam int N    = 1 << AW;
    localparam int G    = NCH / NL;
    localparam int SW   = $clog2(G);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic trig = 1'b0;
    logic [DLW-1:0] cfg_delay = '0;
    logic [AW-1:0]  cfg_roi = '0;
    logic [NCH*DW-1:0] ch_data;
    logic wr_en, busy, rd_valid;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [SW-1:0] rd_slot;
    logic [NL*DW-1:0] lane_data;

    int n_tests = 0;
    int n_fail  = 0;
    int n_strobes = 0;

    ring_roi_ctrl #(
        .ADDR_W(AW), .DLY_W(DLW), .NCH(NCH), .NLANES(NL), .DW(DW), .RD_DIV(RDIV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
        .cfg_delay(cfg_delay), .cfg_roi(cfg_roi), .ch_data(ch_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_slot(rd_slot), .lane_data(lane_data)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] cell_val(int a, int c);
        return DW'(a * 3 + c * 37 + 1);
    endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ch_data[c*DW +: DW] = cell_val(int'(rd_addr), c);
        end
    end

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 writing, 2 countdown, 3 readout
    int m_st = 0, m_ptr = 0, m_cnt = 0, m_stop = 0, m_roi = 1;
    int m_wait = 0, m_k = 0, m_start = 0;
    bit m_strobe = 0;

    task automatic m_enter_read();
        m_st    = 3;
        m_wait  = RDIV;
        m_k     = 0;
        m_start = (m_stop + 1 - m_roi + 2 * N) % N;
    endtask

    always begin
        @(posedge clk);
        #5;
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_strobe = 0;
        end else begin
            case (m_st)
                0: if (arm) m_st = 1;
                1: begin
                    if (trig) begin
                        m_roi = (cfg_roi == 0) ? N : int'(cfg_roi);
                        if (cfg_delay == 0) begin
                            m_stop = m_ptr;
                            m_enter_read();
                        end else begin
                            m_cnt = int'(cfg_delay);
                            m_st = 2;
                        end
                    end
                    m_ptr = (m_ptr + 1) % N;
                end
                2: begin
                    if (m_cnt == 1) begin
                        m_stop = m_ptr;
                        m_enter_read();
                    end else begin
                        m_cnt--;
                    end
                    m_ptr = (m_ptr + 1) % N;
                end
                default: begin
                    if (m_strobe) begin
                        m_k++;
                        if (m_k == m_roi * G) m_st = 0;
                        else m_wait = RDIV - 1;
                    end else begin
                        m_wait--;
                    end
                end
            endcase
            m_strobe = (m_st == 3) && (m_wait == 0);
            check("R3 wr_en", int'(wr_en), int'(m_st == 1 || m_st == 2));
            if (m_st == 1 || m_st == 2) check("R2 wr_addr", int'(wr_addr), m_ptr);
            check("R8 busy", int'(busy), int'(m_st >= 2));
            check("R6 rd_valid", int'(rd_valid), int'(m_strobe));
            if (rd_valid) n_strobes++;
            if (m_strobe) begin
                check("R4 rd_addr", int'(rd_addr), (m_start + m_k / G) % N);
                check("R5 rd_slot", int'(rd_slot), m_k % G);
                for (int l = 0; l < NL; l++) begin
                    check("R5 lane_data", int'(lane_data[l*DW +: DW]),
                          int'(cell_val((m_start + m_k / G) % N, (m_k % G) * NL + l)));
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cyc;
        step(3);
        check("R1 reset wr_en", int'(wr_en), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset rd_valid", int'(rd_valid), 0);
        check("R1 reset wr_addr", int'(wr_addr), 0);
        rst_n = 1'b1;
        step(2);

        pulse_trig();
        check("R7 trigger while idle", int'(busy), 0);

        pulse_arm();
        check("R1 first write cell", int'(wr_addr), 0);
        check("R1 writing after arm", int'(wr_en), 1);
        step(40);

        // plain capture
        cfg_delay = 5; cfg_roi = 8; n_strobes = 0;
        pulse_trig();
        wait_idle();
        check("R4 window strobes", n_strobes, 8 * G);

        // window across cell 0 with disturbances
        pulse_arm();
        while (wr_addr != AW'(1018)) @(negedge clk);
        cfg_delay = 10; cfg_roi = 16; trig = 1'b1; n_strobes = 0;
        @(negedge clk);
        trig = 1'b0;
        cyc = 0;
        while (wr_en) begin
            trig = (cyc == 3);
            if (cyc == 4) begin
                cfg_delay = 50; cfg_roi = 3;
            end
            cyc++;
            @(negedge clk);
        end
        trig = 1'b0;
        check("R3 writes after trigger", cyc, 10);
        step(30);
        pulse_trig();
        pulse_arm();
        check("R9 arm while busy", int'(wr_en), 0);
        check("R7 busy kept", int'(busy), 1);
        wait_idle();
        check("R10 strobes unchanged by cfg", n_strobes, 16 * G);
        pulse_arm();
        check("R9 resume cell", int'(wr_addr), 5);
        check("R9 resume writing", int'(wr_en), 1);

        // zero delay, one-cell window
        cfg_delay = 0; cfg_roi = 1; n_strobes = 0;
        step(7);
        pulse_trig();
        check("R3 zero delay halt", int'(wr_en), 0);
        wait_idle();
        check("R4 one-cell strobes", n_strobes, G);

        // full ring window
        pulse_arm();
        step(100);
        cfg_delay = 3; cfg_roi = 0; n_strobes = 0;
        pulse_trig();
        wait_idle();
        check("R4 full ring strobes", n_strobes, N * G);

        // countdown longer than the ring
        pulse_arm();
        cfg_delay = 2500; cfg_roi = 5; n_strobes = 0;
        step(10);
        pulse_trig();
        wait_idle();
        check("R3 long delay strobes", n_strobes, 5 * G);

        step(5);
        finish_run();
    end

endmodule